// File: doc/BRIEF.md
# Mode-Indexed GPIO Port Controller

This block is an 8-bit general-purpose I/O port for a small register-file microcontroller core. Its data latch sits at a fixed file address and is written by ordinary register writes. Its per-pin control registers have no addresses of their own. These are direction, pullup, input threshold and hysteresis buffer, plus a comparator control register and a shared timer/read-mode register. A 5-bit selector register picks which one a "control write" reaches. For the comparator register, a control write exchanges its contents with the written value, and the previous contents return as the result.

The block drives per-pin output enables and output values, along with pullup and buffer-select signals for the analog pad. It returns read data for the data address. A global read-mode bit chooses whether data reads show the synchronized pin levels or the latched data. Pad inputs and the digital comparator result pass through a two-flop synchronizer. The comparator front end and the timer exist only as plain signals.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset, every pin is an input (pin_oe = 00h), pullups are off (pullup_on = 00h), the hysteresis buffers are off (schmitt_on = 00h), all pins select TTL thresholds (ttl_sel = FFh), the comparator is disabled, and timer_cfg = 00h.
- R2: The selector resets to 1Fh (or to 0Fh when the small variant is chosen), so the first control write after reset goes to the direction register.
- R3: Control writes reach the direction register at selector 0Fh/1Fh, the pullup register at 0Eh/1Eh, the threshold register at 0Dh/1Dh and the hysteresis register at 0Ch/1Ch. The outputs are pin_oe = ~direction, pullup_on = ~pullup, ttl_sel = threshold and schmitt_on = ~hysteresis.
- R4: At selector 18h, a control write stores the written value in the comparator register and, one cycle later, places the previous contents on ctl_rdata. Bit 0 of that result is the synchronized compare result, not a stored bit.
- R5: When comparator register bit 7 is 0, cmp_enable is 1. When bits 7 and 6 are both 0, pin 0 is forced to output (pin_oe[0] = 1) and pin_out[0] carries the synchronized compare result.
- R6: At selector 16h, a control write sends bits 6:0 to timer_cfg and stores bit 7 as the global read mode.
- R7: With read mode 0, rd_data for file address 06h returns the synchronized pin levels, even on pins driven as outputs. With read mode 1, it returns the data latch.
- R8: A register write to address 06h loads the data latch whatever the selector holds, and pin_out follows the latch. Writes to other addresses leave the latch unchanged.
- R9: A control write at any selector value not listed in R3, R4 or R6 changes no register.
- R10: When a selector write and a control write fall in the same cycle, the control write is steered by the selector value held before that cycle.
- R11: A pin change appears on rd_data three clock edges after it is applied (two synchronizer stages plus the read register), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Ordinary register-file write strobe |
| reg_addr | input | 8 | Register-file address for reads and writes |
| reg_wdata | input | 8 | Register-file write data |
| rd_data | output | 8 | Registered read data for the data address |
| mode_wr | input | 1 | Selector register write strobe |
| mode_wdata | input | 5 | Selector write value |
| ctl_wr | input | 1 | Control write strobe (target picked by selector) |
| ctl_wdata | input | 8 | Control write value |
| ctl_rdata | output | 8 | Previous comparator register contents after an exchange |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| cmp_in | input | 1 | Digital comparator result, pin 2 above pin 1 (asynchronous) |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pullup_on | output | 8 | Per-pin pullup connect |
| ttl_sel | output | 8 | Per-pin threshold select, 1 = TTL, 0 = CMOS |
| schmitt_on | output | 8 | Per-pin hysteresis buffer enable |
| cmp_enable | output | 1 | Comparator enable |
| timer_cfg | output | 7 | Timer configuration bits |

## Verification
Two pairs of functions can land on the same clock edge. The first is a selector write together with a control write. The bench asserts both strobes in one cycle while the selector holds 18h and then judges by ports: ctl_rdata must show the old comparator contents, and pin_oe must be unchanged, so the write went to the comparator and not the direction register. The second is the comparator route into pin 0 together with an ordinary data latch value. The bench holds pin_out[0]'s latch bit at the opposite level to the compare result, then checks that the route selects the compare result and that clearing the route restores the latch bit and the direction-controlled enable.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;
  localparam int SEL_W = 5;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_DIR,
    TGT_PULL,
    TGT_LVL,
    TGT_HYST,
    TGT_CMP,
    TGT_TMR
  } ctl_tgt_e;

  function automatic ctl_tgt_e decode_sel(input logic [SEL_W-1:0] sel);
    ctl_tgt_e t;
    case (sel)
      5'h0F, 5'h1F: t = TGT_DIR;
      5'h0E, 5'h1E: t = TGT_PULL;
      5'h0D, 5'h1D: t = TGT_LVL;
      5'h0C, 5'h1C: t = TGT_HYST;
      5'h18:        t = TGT_CMP;
      5'h16:        t = TGT_TMR;
      default:      t = TGT_NONE;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_mode_pkg::*;
#(
  parameter int          PW        = 8,
  parameter logic [SEL_W-1:0] SEL_RST = 5'h1F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [SEL_W-1:0] mode_wdata,
  input  logic             ctl_wr,
  input  logic [PW-1:0]    ctl_wdata,
  input  logic             cmp_bit,
  output logic [SEL_W-1:0] sel_q,
  output logic [PW-1:0]    dir_q,
  output logic [PW-1:0]    pull_q,
  output logic [PW-1:0]    lvl_q,
  output logic [PW-1:0]    hyst_q,
  output logic [PW-1:1]    cmp_q,
  output logic [PW-1:0]    tmr_q,
  output logic [PW-1:0]    xchg_q
);
  ctl_tgt_e tgt;
  assign tgt = decode_sel(sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_RST;
      dir_q  <= '1;
      pull_q <= '1;
      lvl_q  <= '1;
      hyst_q <= '1;
      cmp_q  <= '1;
      tmr_q  <= '0;
      xchg_q <= '0;
    end else begin
      if (mode_wr) sel_q <= mode_wdata;
      if (ctl_wr) begin
        unique case (tgt)
          TGT_DIR:  dir_q  <= ctl_wdata;
          TGT_PULL: pull_q <= ctl_wdata;
          TGT_LVL:  lvl_q  <= ctl_wdata;
          TGT_HYST: hyst_q <= ctl_wdata;
          TGT_TMR:  tmr_q  <= ctl_wdata;
          TGT_CMP: begin
            cmp_q  <= ctl_wdata[PW-1:1];
            xchg_q <= {cmp_q, cmp_bit};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
  import gpio_mode_pkg::*;
#(
  parameter int          PORT_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  DATA_ADDR = 8'h06,
  parameter bit          WIDE_SEL  = 1'b1,
  parameter int          SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] rd_data,
  input  logic              mode_wr,
  input  logic [SEL_W-1:0]  mode_wdata,
  input  logic              ctl_wr,
  input  logic [PORT_W-1:0] ctl_wdata,
  output logic [PORT_W-1:0] ctl_rdata,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              cmp_in,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pullup_on,
  output logic [PORT_W-1:0] ttl_sel,
  output logic [PORT_W-1:0] schmitt_on,
  output logic              cmp_enable,
  output logic [PORT_W-2:0] timer_cfg
);
  localparam logic [SEL_W-1:0] SEL_RST = WIDE_SEL ? 5'h1F : 5'h0F;
  localparam int CMP_EN_BIT  = PORT_W - 1;
  localparam int CMP_RTE_BIT = PORT_W - 2;

  logic [PORT_W:0]   sync_d, sync_q;
  logic [PORT_W-1:0] pin_s;
  logic              cmp_s;
  logic [SEL_W-1:0]  sel_q;
  logic [PORT_W-1:0] dir_q, pull_q, lvl_q, hyst_q, tmr_q;
  logic [PORT_W-1:1] cmp_q;
  logic [PORT_W-1:0] data_q;
  logic              route;

  assign sync_d = {cmp_in, pin_in};
  assign pin_s  = sync_q[PORT_W-1:0];
  assign cmp_s  = sync_q[PORT_W];

  gpio_sync #(.W(PORT_W + 1), .STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_d),
    .q   (sync_q)
  );

  gpio_ctl_regs #(.PW(PORT_W), .SEL_RST(SEL_RST)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .cmp_bit    (cmp_s),
    .sel_q      (sel_q),
    .dir_q      (dir_q),
    .pull_q     (pull_q),
    .lvl_q      (lvl_q),
    .hyst_q     (hyst_q),
    .cmp_q      (cmp_q),
    .tmr_q      (tmr_q),
    .xchg_q     (ctl_rdata)
  );

  // Data latch and registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      rd_data <= '0;
    end else begin
      if (reg_wr && reg_addr == DATA_ADDR[ADDR_W-1:0]) data_q <= reg_wdata;
      if (reg_addr == DATA_ADDR[ADDR_W-1:0])
        rd_data <= tmr_q[PORT_W-1] ? data_q : pin_s;
      else
        rd_data <= '0;
    end
  end

  // Pad-side controls: one gate level after the holding flops
  assign cmp_enable = ~cmp_q[CMP_EN_BIT];
  assign route      = ~cmp_q[CMP_EN_BIT] & ~cmp_q[CMP_RTE_BIT];
  assign pullup_on  = ~pull_q;
  assign schmitt_on = ~hyst_q;
  assign ttl_sel    = lvl_q;
  assign timer_cfg  = tmr_q[PORT_W-2:0];

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_pad
      if (i == 0) begin : g_p0
        assign pin_oe[i]  = route | ~dir_q[i];
        assign pin_out[i] = route ? cmp_s : data_q[i];
      end else begin : g_pn
        assign pin_oe[i]  = ~dir_q[i];
        assign pin_out[i] = data_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_mode_port_chk.sv
module gpio_mode_port_chk #(
  parameter int PORT_W = 8,
  parameter int SEL_W  = 5,
  parameter logic [SEL_W-1:0] SEL_RST = 5'h1F
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [7:0]        reg_addr,
  input logic [SEL_W-1:0]  sel_q,
  input logic              ctl_wr,
  input logic [PORT_W-1:0] ctl_wdata,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pullup_on,
  input logic [PORT_W-1:0] ttl_sel,
  input logic [PORT_W-1:0] schmitt_on,
  input logic              cmp_enable,
  input logic [PORT_W-2:0] timer_cfg
);
  logic unmapped;
  assign unmapped = !(sel_q[3:0] inside {4'hF, 4'hE, 4'hD, 4'hC}) &&
                    sel_q != 5'h18 && sel_q != 5'h16;

  // R2
  sel_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sel_q == SEL_RST);

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && sel_q[3:0] == 4'hF) |=> pin_oe[PORT_W-1:1] == ~$past(ctl_wdata[PORT_W-1:1]));

  // R4
  cmp_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && sel_q == 5'h18) |=> cmp_enable == ~$past(ctl_wdata[PORT_W-1]));

  // R6
  tmr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && sel_q == 5'h16) |=> timer_cfg == $past(ctl_wdata[PORT_W-2:0]));

  // R8
  other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr != 8'h06) |=> $stable(pin_out[PORT_W-1:1]));

  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && unmapped) |=> $stable(pullup_on) && $stable(ttl_sel) &&
                             $stable(schmitt_on) && $stable(timer_cfg) &&
                             $stable(cmp_enable));
endmodule

bind gpio_mode_port gpio_mode_port_chk #(
  .PORT_W(PORT_W), .SEL_W(gpio_mode_pkg::SEL_W), .SEL_RST(SEL_RST)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr[7:0]),
  .sel_q(sel_q), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .pin_oe(pin_oe), .pin_out(pin_out), .pullup_on(pullup_on),
  .ttl_sel(ttl_sel), .schmitt_on(schmitt_on), .cmp_enable(cmp_enable),
  .timer_cfg(timer_cfg)
);

// File: tb/gpio_mode_port_tb_top.sv
module gpio_mode_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h06;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       mode_wr = 1'b0;
  logic [4:0] mode_wdata = 5'h00;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic [7:0] pin_in = 8'h00;
  logic       cmp_in = 1'b0;
  logic [7:0] pin_oe, pin_out, pullup_on, ttl_sel, schmitt_on;
  logic       cmp_enable;
  logic [6:0] timer_cfg;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_mode_port dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .pin_in(pin_in), .cmp_in(cmp_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pullup_on(pullup_on),
    .ttl_sel(ttl_sel), .schmitt_on(schmitt_on), .cmp_enable(cmp_enable),
    .timer_cfg(timer_cfg)
  );

  // {selector, value, exp pin_oe, exp pullup_on, exp schmitt_on, exp ttl_sel}
  localparam logic [47:0] VECS [6] = '{
    {8'h0F, 8'hF1, 8'h0E, 8'h00, 8'h00, 8'hFF},  // R3 direction
    {8'h1E, 8'h3C, 8'h0E, 8'hC3, 8'h00, 8'hFF},  // R3 pullup
    {8'h1D, 8'h55, 8'h0E, 8'hC3, 8'h00, 8'h55},  // R3 threshold
    {8'h1C, 8'h0F, 8'h0E, 8'hC3, 8'hF0, 8'h55},  // R3 hysteresis
    {8'h13, 8'h00, 8'h0E, 8'hC3, 8'hF0, 8'h55},  // R9 unmapped
    {8'h0E, 8'hFF, 8'h0E, 8'h00, 8'hF0, 8'h55}   // R3 pullup, small code
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic set_sel(input logic [4:0] s);
    mode_wr = 1'b1; mode_wdata = s;
    tick(1);
    mode_wr = 1'b0;
  endtask

  task automatic ctl_put(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic data_put(input logic [7:0] a, input logic [7:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    tick(1);
    reg_wr = 1'b0; reg_addr = 8'h06;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pullup_on", pullup_on, 8'h00);
    chk("R1 schmitt_on", schmitt_on, 8'h00);
    chk("R1 ttl_sel", ttl_sel, 8'hFF);
    chk("R1 cmp_enable", {7'd0, cmp_enable}, 8'h00);
    chk("R1 timer_cfg", {1'b0, timer_cfg}, 8'h00);
    rst = 1'b0;
    tick(1);

    // R2 first control write lands in direction
    ctl_put(8'h00);
    chk("R2 pin_oe", pin_oe, 8'hFF);

    // R3 / R9 table
    for (int i = 0; i < 6; i++) begin
      set_sel(VECS[i][44:40]);
      ctl_put(VECS[i][39:32]);
      chk(VECS[i][47:40] == 8'h13 ? "R9 pin_oe" : "R3 pin_oe", pin_oe, VECS[i][31:24]);
      chk(VECS[i][47:40] == 8'h13 ? "R9 pullup_on" : "R3 pullup_on", pullup_on, VECS[i][23:16]);
      chk(VECS[i][47:40] == 8'h13 ? "R9 schmitt_on" : "R3 schmitt_on", schmitt_on, VECS[i][15:8]);
      chk(VECS[i][47:40] == 8'h13 ? "R9 ttl_sel" : "R3 ttl_sel", ttl_sel, VECS[i][7:0]);
    end

    // R8 data latch
    data_put(8'h06, 8'hA5);
    chk("R8 pin_out", pin_out, 8'hA5);
    data_put(8'h07, 8'h5A);
    chk("R8 other address", pin_out, 8'hA5);

    // R7 pin read mode, outputs read as pin level
    pin_in = 8'h3C;
    tick(3);
    chk("R7 pin read", rd_data, 8'h3C);
    set_sel(5'h16);
    ctl_put(8'hA5);
    chk("R6 timer_cfg", {1'b0, timer_cfg}, 8'h25);
    tick(1);
    chk("R7 latch read", rd_data, 8'hA5);
    ctl_put(8'h00);
    tick(1);
    chk("R7 back to pins", rd_data, 8'h3C);

    // R11 synchronizer latency
    pin_in = 8'hC3;
    tick(2);
    chk("R11 not yet", rd_data, 8'h3C);
    tick(1);
    chk("R11 arrived", rd_data, 8'hC3);

    // R4 / R5 comparator exchange and routing
    cmp_in = 1'b0;
    tick(3);
    set_sel(5'h18);
    ctl_put(8'h3F);
    chk("R4 old contents", ctl_rdata, 8'hFE);
    chk("R5 cmp_enable", {7'd0, cmp_enable}, 8'h01);
    chk("R5 forced oe", pin_oe, 8'h0F);
    chk("R5 routed low", pin_out, 8'hA4);
    cmp_in = 1'b1;
    tick(2);
    chk("R5 routed high", pin_out, 8'hA5);
    ctl_put(8'hC0);
    chk("R4 compare bit", ctl_rdata, 8'h3F);
    chk("R5 unrouted oe", pin_oe, 8'h0E);
    chk("R5 disabled", {7'd0, cmp_enable}, 8'h00);

    // R10 selector and control write in the same cycle
    mode_wr = 1'b1; mode_wdata = 5'h0F;
    ctl_wr = 1'b1; ctl_wdata = 8'hFF;
    tick(1);
    mode_wr = 1'b0; ctl_wr = 1'b0;
    chk("R10 old selector used", ctl_rdata, 8'hC1);
    chk("R10 direction untouched", pin_oe, 8'h0E);
    ctl_put(8'h00);
    chk("R10 new selector after", pin_oe, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule